// File: doc/BRIEF.md
# Bit-Slip Deserializer with Slip Rollover

This block turns one or more serial bit streams into parallel words of `J` bits. Every channel is shifted in on a fast bit clock. A parallel clock, running at 1/J of the bit rate, takes a J-bit window out of a short bit history for each channel. A shared slip offset chooses where that window sits. Each rising edge of the alignment request moves the word boundary by one bit. Logic downstream can search for a known control character and pulse the request until the character comes out whole.

The slip offset counts up to a configurable wrap point (`SLIP_WRAP`, from 1 to 11), and the wrap point need not equal `J`. A flag is high while the offset sits at the last position before the wrap. A clear input puts the offset back to zero. When `J` is 2 the bit clock runs at the parallel rate, and each channel takes one bit on each edge of it (double-data-rate capture) in place of a one-bit-per-cycle shift register. The `REG_OUT` parameter chooses between a registered parallel output and a combinational one.

Top module: `bitslip_deser`

## Requirements
- R1: A word is presented MSB first: the earliest received bit of a word appears in the highest bit of that channel's J-bit field.
- R2: Each accepted slip moves the boundary one bit toward older data. With a J-periodic input, the new word equals the previous word rotated right by one bit.
- R3: With registered output, the word for the new boundary appears after the third parallel-clock rising edge that follows the rise of `align_req`. After the second edge the old word is still present.
- R4: A slip is taken only on a rising edge of `align_req`. Holding it high for many cycles gives exactly one slip.
- R5: The slip offset runs from 0 to `SLIP_WRAP`-1. The slip taken at `SLIP_WRAP`-1 returns it to 0, which restores the zero-slip word.
- R6: `slip_max` is 1 exactly when the offset equals `SLIP_WRAP`-1, and 0 at all other offsets.
- R7: Channel c occupies bits `[c*J +: J]` of `pword_out`, so channel 0 is in the least significant J bits.
- R8: `align_clr` high at a parallel-clock edge sets the offset to 0 at that edge and clears `slip_max`. The zero-slip word follows one edge later.
- R9: While `rst_n` is low, `pword_out` is all zeros and the offset is 0.
- R10: With J = 2, a channel word is {bit taken at the rising bit-clock edge, bit taken at the following falling edge}. A slip rotates this pair as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Serial bit clock (with J = 2, a clock at the parallel rate whose two edges both capture data) |
| clk_par | input | 1 | Parallel word clock, 1/J of the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sdata_in | input | CH | One serial data bit per channel |
| align_req | input | 1 | Slip request; each rising edge adds one bit of slip |
| align_clr | input | 1 | Sets the slip offset back to zero |
| pword_out | output | CH*J | Parallel words, channel 0 in the least significant bits |
| slip_max | output | 1 | High while the offset is at the last position before wrap |

## Verification
The bench feeds a repeating one-hot pattern to channel 0 and a two-hot pattern to channel 1. A design that reversed the bit order, swapped the channels or rotated the wrong way therefore produces words that fail the rotation checks. The wrap point is set to 6 with J = 4. A counter that did not wrap, or wrapped at J, would then return a word rotated by two positions where the unrotated word is expected. The bench samples one cycle before and one cycle after the specified latency, so an output that arrives a cycle early or late is reported. A long held request exposes level-triggered slipping, and a J = 2 instance checks the order of the rising-edge and falling-edge bits.

// File: rtl/bitslip_deser.sv
module bitslip_deser #(
  parameter int J         = 4,
  parameter int CH        = 2,
  parameter int SLIP_WRAP = 6,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic            clk_bit,
  input  logic            clk_par,
  input  logic            rst_n,
  input  logic [CH-1:0]   sdata_in,
  input  logic            align_req,
  input  logic            align_clr,
  output logic [CH*J-1:0] pword_out,
  output logic            slip_max
);
  localparam int HW = J + SLIP_WRAP;
  localparam int OW = (SLIP_WRAP < 2) ? 1 : $clog2(SLIP_WRAP);
  localparam logic [OW-1:0] LAST = OW'(SLIP_WRAP - 1);

  logic [OW-1:0] slip_off;
  logic          align_s, align_e;
  wire           align_rise = align_s & ~align_e;

  always_ff @(posedge clk_par or negedge rst_n) begin
    if (!rst_n) begin
      align_s  <= 1'b0;
      align_e  <= 1'b0;
      slip_off <= '0;
    end else begin
      align_s <= align_req;
      align_e <= align_s;
      if (align_clr)
        slip_off <= '0;
      else if (align_rise)
        slip_off <= (slip_off == LAST) ? '0 : slip_off + OW'(1);
    end
  end

  assign slip_max = (slip_off == LAST);

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [HW-1:0] hist;
    logic [J-1:0]  win;

    if (J == 2) begin : g_ddr
      logic rise_bit;
      always_ff @(posedge clk_bit or negedge rst_n)
        if (!rst_n) rise_bit <= 1'b0;
        else        rise_bit <= sdata_in[c];
      always_ff @(negedge clk_bit or negedge rst_n)
        if (!rst_n) hist <= '0;
        else        hist <= {hist[HW-3:0], rise_bit, sdata_in[c]};
    end else begin : g_sdr
      always_ff @(posedge clk_bit or negedge rst_n)
        if (!rst_n) hist <= '0;
        else        hist <= {hist[HW-2:0], sdata_in[c]};
    end

    assign win = hist[slip_off +: J];

    if (REG_OUT) begin : g_reg
      logic [J-1:0] wq;
      always_ff @(posedge clk_par or negedge rst_n)
        if (!rst_n) wq <= '0;
        else        wq <= win;
      assign pword_out[c*J +: J] = wq;
    end else begin : g_comb
      assign pword_out[c*J +: J] = win;
    end
  end
endmodule

// File: rtl/bitslip_deser_chk.sv
module bitslip_deser_chk #(
  parameter int WRAP = 6,
  parameter int OW   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rise,
  input logic          clr,
  input logic [OW-1:0] off,
  input logic          max_o
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !clr && off != OW'(WRAP - 1)) |=> off == $past(off) + OW'(1));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !clr && off == OW'(WRAP - 1)) |=> off == '0);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !clr) |=> $stable(off));

  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (off == '0) && (max_o == (WRAP == 1)));

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(off) < WRAP);
endmodule

bind bitslip_deser bitslip_deser_chk #(.WRAP(SLIP_WRAP), .OW(OW)) u_chk (
  .clk(clk_par), .rst_n(rst_n), .rise(align_rise), .clr(align_clr),
  .off(slip_off), .max_o(slip_max)
);

// File: tb/bitslip_deser_bench.sv
`timescale 1ns/1ps
module bitslip_deser_bench;
  localparam logic [3:0] PAT0 = 4'b1000;
  localparam logic [3:0] PAT1 = 4'b1100;

  logic clk_bit = 1'b0, clk_par = 1'b0, rst_n = 1'b0;
  logic [1:0] sdata = 2'b00;
  logic align_req = 1'b0, align_clr = 1'b0, align2 = 1'b0, d_ddr = 1'b0;
  logic [7:0] pword;
  logic [1:0] dword;
  logic smax, dmax;
  logic [3:0] base0, base1;
  int n_tests = 0, n_fail = 0;
  int ph = 0;

  bitslip_deser #(.J(4), .CH(2), .SLIP_WRAP(6), .REG_OUT(1'b1)) u_bitslip_deser (
    .clk_bit(clk_bit), .clk_par(clk_par), .rst_n(rst_n), .sdata_in(sdata),
    .align_req(align_req), .align_clr(align_clr), .pword_out(pword), .slip_max(smax));

  bitslip_deser #(.J(2), .CH(1), .SLIP_WRAP(3), .REG_OUT(1'b1)) u_ddr (
    .clk_bit(clk_par), .clk_par(clk_par), .rst_n(rst_n), .sdata_in(d_ddr),
    .align_req(align2), .align_clr(1'b0), .pword_out(dword), .slip_max(dmax));

  initial forever #2.5 clk_bit = ~clk_bit;

  always @(negedge clk_bit) begin
    ph = ph + 1;
    if (ph[0]) clk_par = ~clk_par;
    sdata[0] = PAT0[3 - (ph % 4)];
    sdata[1] = PAT1[3 - (ph % 4)];
  end

  always @(posedge clk_par) begin #5; d_ddr = 1'b0; end
  always @(negedge clk_par) begin #5; d_ddr = 1'b1; end

  function automatic logic [3:0] rotr(input logic [3:0] w, input int n);
    logic [3:0] r = w;
    for (int i = 0; i < n; i++) r = {r[0], r[3:1]};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit ddr);
    @(negedge clk_par);
    if (ddr) align2 = 1'b1; else align_req = 1'b1;
    @(negedge clk_par);
    align2 = 1'b0; align_req = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_par);
    chk(pword == 8'h00, "R9 word in reset", pword, 8'h00);
    chk(smax == 1'b0, "R9 max in reset", {7'd0, smax}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk_par);
    base0 = pword[3:0];
    base1 = pword[7:4];
    chk($countones(base0) == 1, "R7 channel 0 in low bits", {4'd0, base0}, {4'd0, PAT0});
    chk(base1 == (base0 | rotr(base0, 1)), "R1 MSB first order",
        {4'd0, base1}, {4'd0, base0 | rotr(base0, 1)});
  endtask

  task automatic t_first_slip();
    pulse(1'b0);
    @(negedge clk_par);
    chk(pword[3:0] == base0, "R3 old word after second edge", {4'd0, pword[3:0]}, {4'd0, base0});
    @(negedge clk_par);
    chk(pword[3:0] == rotr(base0, 1), "R2 ch0 rotated by one", {4'd0, pword[3:0]}, {4'd0, rotr(base0, 1)});
    chk(pword[7:4] == rotr(base1, 1), "R7 ch1 rotated by one", {4'd0, pword[7:4]}, {4'd0, rotr(base1, 1)});
    chk(smax == 1'b0, "R6 max low at offset 1", {7'd0, smax}, 8'h00);
  endtask

  task automatic t_held_level();
    @(negedge clk_par); align_req = 1'b1;
    repeat (8) @(negedge clk_par);
    align_req = 1'b0;
    repeat (3) @(negedge clk_par);
    chk(pword[3:0] == rotr(base0, 2), "R4 held level gives one slip", {4'd0, pword[3:0]}, {4'd0, rotr(base0, 2)});
  endtask

  task automatic t_wrap();
    for (int k = 3; k <= 6; k++) begin
      pulse(1'b0);
      repeat (2) @(negedge clk_par);
      chk(smax == (k == 5), "R6 max flag at offset", {7'd0, smax}, {7'd0, k == 5});
    end
    chk(pword[3:0] == base0, "R5 wrap restores zero slip", {4'd0, pword[3:0]}, {4'd0, base0});
  endtask

  task automatic t_clear();
    for (int k = 0; k < 5; k++) begin pulse(1'b0); @(negedge clk_par); end
    @(negedge clk_par);
    chk(smax == 1'b1, "R6 max before clear", {7'd0, smax}, 8'h01);
    @(negedge clk_par); align_clr = 1'b1;
    @(negedge clk_par); align_clr = 1'b0;
    chk(smax == 1'b0, "R8 clear drops max", {7'd0, smax}, 8'h00);
    @(negedge clk_par);
    chk(pword[3:0] == base0, "R8 clear restores word", {4'd0, pword[3:0]}, {4'd0, base0});
  endtask

  task automatic t_ddr();
    chk(dword == 2'b10, "R10 rise bit then fall bit", {6'd0, dword}, 8'h02);
    pulse(1'b1); repeat (2) @(negedge clk_par);
    chk(dword == 2'b01, "R10 ddr slip rotates", {6'd0, dword}, 8'h01);
    pulse(1'b1); repeat (2) @(negedge clk_par);
    chk(dmax == 1'b1, "R6 ddr max at offset 2", {7'd0, dmax}, 8'h01);
    pulse(1'b1); repeat (2) @(negedge clk_par);
    chk(dmax == 1'b0 && dword == 2'b10, "R5 ddr wrap", {5'd0, dmax, dword}, 8'h02);
  endtask

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_first_slip();
    t_held_level();
    t_wrap();
    t_clear();
    t_ddr();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule